// File: doc/BRIEF.md
# PLL Enable and Lock-Time Controller

This block is the control and status side of three on-chip PLLs. The analog loops are not modelled: each PLL appears only as a `lock_in` flag. Software writes one mode word and three lock-time words over a simple register port. The mode word switches each PLL on or off and picks multiply or divide operation. It also steers each PLL output between the slow 32 kHz oscillator and the synthesized frequency, and it carries two oscillator-routing bits. The block drives all of these settings out as plain pins.

For every enabled PLL, a lock-time counter counts peripheral-clock ticks, which arrive on a one-cycle `tick` enable. The start-status bit of that PLL rises when the programmed number of ticks has elapsed. It does not depend on whether the loop has actually locked. A second status bit tracks the real lock input, and only while the PLL runs in divide mode. Turning a PLL off clears its counter and both of its status bits.

The register port is plain control with no handshake. A write takes effect at the clock edge where `wr_en` is high. `rdata` shows, without a register stage, the word selected by `addr`.

Top module: `pll_ctl`

## Requirements
- R1: After reset, every stored bit is zero. All mode pins, `rdata` for every address, and both kinds of status bit read zero.
- R2: Address 0 is the mode word. Bits 2:0 enable PLL 2..0. Only bits 0,1,2,4,5,6,8,16,17,18 are stored (read-back mask 0x0007_0177), and all other bits read 0.
- R3: Mode bit 4 and bit 5 select divide mode (1) or multiply mode (0) for PLL0 and PLL1, driven on `div_mode[1:0]`. `div_mode[2]` is always 1. Bit 6 selects the alternate divide-mode oscillator for PLL2 (`pll2_alt_osc`), and bit 8 picks the oscillator feeding the oscillator source (`osc_sel`).
- R4: Mode bits 18:16 drive `out_sel[2:0]`. A 0 selects the slow oscillator and a 1 selects the PLL frequency.
- R5: Addresses 1, 2 and 3 hold the lock counts of PLL0, PLL1 and PLL2. Only bits 21:0 are stored, and bits 31:22 read 0.
- R6: Address 4 is the status word. Bit n (start status) sets one cycle after PLL n, enabled, has counted as many ticks as its lock count. It stays set while the PLL is enabled, and `lock_in` has no effect on it.
- R7: Status bit 4+n is, one cycle later, the AND of PLL n enabled, PLL n in divide mode, and `lock_in[n]`. In multiply mode it stays 0.
- R8: A disabled PLL has a zero counter and both of its status bits at 0. A later enable counts again from zero.
- R9: The lock count is captured while the PLL is disabled. A write to it while the PLL is enabled does not change or restart the current count, and it applies from the next enable.
- R10: The status word is read-only, and writes to addresses 4..7 change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Peripheral-clock tick enable |
| lock_in | input | 3 | Analog lock flag per PLL |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pll_en | output | 3 | PLL power enable |
| div_mode | output | 3 | 1 = divide mode |
| out_sel | output | 3 | 1 = PLL frequency, 0 = slow oscillator |
| pll2_alt_osc | output | 1 | Alternate divide-mode oscillator for PLL2 |
| osc_sel | output | 1 | Oscillator choice for the oscillator source |

## Verification
Two events can fall in the same cycle: lock-count expiry, and a mode write that turns the PLL off or a count write that targets the running PLL. The bench sets small lock counts and drives random ticks and random writes at a high rate, so such collisions occur many times. A directed case also writes a shorter count in the middle of a run. Each cycle, the status word and pins are compared with a bench model built from R6, R8 and R9. In that model, a disable always wins over expiry, and a count written during a run waits for the next enable.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int NPLL   = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam int B_DIVM   = 4;
  localparam int B_ALT2   = 6;
  localparam int B_OSCSEL = 8;
  localparam int B_OUTSEL = 16;
  localparam int B_DMLOCK = 4;

  typedef struct packed {
    logic [NPLL-1:0] en;
    logic [1:0]      divm;
    logic            alt2;
    logic            oscsel;
    logic [NPLL-1:0] outsel;
  } mode_t;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_ctl_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output mode_t                  mode,
  output logic [NPLL*CNT_W-1:0]  lcnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (wr_en && addr == A_MODE) begin
      mode.en     <= wdata[NPLL-1:0];
      mode.divm   <= wdata[B_DIVM+1:B_DIVM];
      mode.alt2   <= wdata[B_ALT2];
      mode.oscsel <= wdata[B_OSCSEL];
      mode.outsel <= wdata[B_OUTSEL+NPLL-1:B_OUTSEL];
    end
  end

  for (genvar n = 0; n < NPLL; n++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        lcnt[n*CNT_W +: CNT_W] <= '0;
      else if (wr_en && addr == A_CNT0 + ADDR_W'(n))
        lcnt[n*CNT_W +: CNT_W] <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             div_mode,
  input  logic             lock_in,
  input  logic [CNT_W-1:0] lcnt,
  output logic             done,
  output logic             dm_lock
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      tgt     <= '0;
      done    <= 1'b0;
      dm_lock <= 1'b0;
    end else begin
      dm_lock <= en & div_mode & lock_in;
      if (!en) begin
        cnt  <= '0;
        done <= 1'b0;
        tgt  <= lcnt;
      end else if (!done) begin
        if (cnt == tgt) done <= 1'b1;
        else if (tick)  cnt  <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_LE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= tgt); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && en |=> done); // R6
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!done && !dm_lock && cnt == '0)); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (!en || $stable(tgt))); // R9
  AST_MM_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && div_mode && lock_in) |=> !dm_lock); // R7
endmodule

// File: rtl/pll_ctl.sv
module pll_ctl
  import pll_ctl_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPLL-1:0]   lock_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NPLL-1:0]   pll_en,
  output logic [NPLL-1:0]   div_mode,
  output logic [NPLL-1:0]   out_sel,
  output logic              pll2_alt_osc,
  output logic              osc_sel
);
  mode_t                 mode;
  logic [NPLL*CNT_W-1:0] lcnt;
  logic [NPLL-1:0]       done;
  logic [NPLL-1:0]       dm_lock;

  pll_cfg_regs #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .mode(mode), .lcnt(lcnt)
  );

  for (genvar n = 0; n < NPLL; n++) begin : g_pll
    if (n < 2) begin : g_sel
      assign div_mode[n] = mode.divm[n];
    end else begin : g_fix
      assign div_mode[n] = 1'b1;
    end
    pll_lock_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .en(mode.en[n]), .tick(tick),
      .div_mode(div_mode[n]), .lock_in(lock_in[n]),
      .lcnt(lcnt[n*CNT_W +: CNT_W]), .done(done[n]), .dm_lock(dm_lock[n])
    );
  end

  assign pll_en       = mode.en;
  assign out_sel      = mode.outsel;
  assign pll2_alt_osc = mode.alt2;
  assign osc_sel      = mode.oscsel;

  always_comb begin
    rdata = '0;
    if (addr == A_MODE) begin
      rdata[NPLL-1:0]                  = mode.en;
      rdata[B_DIVM+1:B_DIVM]           = mode.divm;
      rdata[B_ALT2]                    = mode.alt2;
      rdata[B_OSCSEL]                  = mode.oscsel;
      rdata[B_OUTSEL+NPLL-1:B_OUTSEL]  = mode.outsel;
    end else if (addr == A_STATUS) begin
      rdata[NPLL-1:0]                  = done;
      rdata[B_DMLOCK+NPLL-1:B_DMLOCK]  = dm_lock;
    end else if (addr < A_STATUS) begin
      for (int n = 0; n < NPLL; n++)
        if (addr == A_CNT0 + ADDR_W'(n))
          rdata[CNT_W-1:0] = lcnt[n*CNT_W +: CNT_W];
    end
  end

  AST_PLL2_DIVIDE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_MODE |=> div_mode[2]); // R3
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= A_STATUS |=> $stable(mode) && $stable(lcnt)); // R10
endmodule

// File: tb/pll_ctl_tb_top.sv
module pll_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  lock_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  pll_en, div_mode, out_sel;
  logic        pll2_alt_osc, osc_sel;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pll_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lock_in(lock_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pll_en(pll_en), .div_mode(div_mode), .out_sel(out_sel),
    .pll2_alt_osc(pll2_alt_osc), .osc_sel(osc_sel)
  );

  // Reference model built from the requirements
  logic [31:0] m_mode;
  logic [21:0] m_lc  [3];
  logic [21:0] m_run [3];
  logic [21:0] m_tgt [3];
  logic [2:0]  m_done, m_dml;

  function automatic logic m_dm(input int n);
    return (n == 2) ? 1'b1 : m_mode[4+n];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= '0; m_done <= '0; m_dml <= '0;
      for (int n = 0; n < 3; n++) begin
        m_lc[n] <= '0; m_run[n] <= '0; m_tgt[n] <= '0;
      end
    end else begin
      for (int n = 0; n < 3; n++) begin
        m_dml[n] <= m_mode[n] & m_dm(n) & lock_in[n];
        if (!m_mode[n]) begin
          m_run[n] <= '0; m_done[n] <= 1'b0; m_tgt[n] <= m_lc[n];
        end else if (!m_done[n]) begin
          if (m_run[n] >= m_tgt[n]) m_done[n] <= 1'b1;
          else if (tick) m_run[n] <= m_run[n] + 1'b1;
        end
      end
      if (wr_en) begin
        if (addr == 3'd0) m_mode <= wdata & 32'h0007_0177;
        else if (addr >= 3'd1 && addr <= 3'd3) m_lc[addr-1] <= wdata[21:0];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 3'd0) return m_mode;
    if (a >= 3'd1 && a <= 3'd3) return {10'd0, m_lc[a-1]};
    if (a == 3'd4) return {25'd0, m_dml, 1'b0, m_done};
    return '0;
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] e;
    e = m_read(addr);
    chk(rdata === e, tag, rdata, e);
    chk(pll_en === m_mode[2:0] && out_sel === m_mode[18:16] &&
        div_mode === {1'b1, m_mode[5:4]} && pll2_alt_osc === m_mode[6] &&
        osc_sel === m_mode[8], {tag, " pins R2 R3 R4"},
        {16'd0, osc_sel, pll2_alt_osc, out_sel, div_mode, pll_en},
        {16'd0, m_mode[8], m_mode[6], m_mode[18:16], 1'b1, m_mode[5:4], m_mode[2:0]});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    wr_en = 1'b1; addr = a; wdata = d;
    step(tag);
  endtask

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at every address
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk(rdata === 32'd0, "R1 reset read", rdata, 32'd0);
    end
    // R2 mask
    wr(3'd0, 32'hFFFF_FFFF, "R2 mode all ones");
    chk(rdata === 32'h0007_0177, "R2 mask", rdata, 32'h0007_0177);
    wr(3'd0, 32'h0, "R2 clear");
    // R5 count width
    wr(3'd2, 32'hFFFF_FFFF, "R5 count write");
    chk(rdata === 32'h003F_FFFF, "R5 count width", rdata, 32'h003F_FFFF);
    // R10 status not writable
    wr(3'd4, 32'hFFFF_FFFF, "R10 status write");
    addr = 3'd2; #1;
    chk(rdata === 32'h003F_FFFF, "R10 count kept", rdata, 32'h003F_FFFF);
    addr = 3'd0; #1;
    chk(rdata === 32'h0, "R10 mode kept", rdata, 32'h0);
    // R6 expiry independent of lock: count 3, ticks every cycle, lock low
    wr(3'd1, 32'd3, "R6 count");
    lock_in = 3'b000; tick = 1'b1;
    wr(3'd0, 32'h0001_0001, "R6 enable");
    addr = 3'd4;
    for (int i = 0; i < 3; i++) begin
      step("R6 counting");
      chk(rdata[0] === 1'b0, "R6 not yet", rdata, 32'd0);
    end
    step("R6 expiry");
    chk(rdata[0] === 1'b1, "R6 start set", rdata, 32'd1);
    // R7 multiply mode keeps lock bit low, divide mode follows
    lock_in = 3'b111;
    addr = 3'd4; step("R7 multiply");
    chk(rdata[4] === 1'b0, "R7 multiply zero", rdata, 32'd0);
    wr(3'd0, 32'h0000_0011, "R7 divide");
    addr = 3'd4; step("R7 divide lock");
    chk(rdata[4] === 1'b1, "R7 divide lock set", rdata, 32'h10);
    // R8 disable clears
    wr(3'd0, 32'h0, "R8 disable");
    addr = 3'd4; step("R8 cleared");
    chk(rdata === 32'd0, "R8 status cleared", rdata, 32'd0);
    // R9 count rewrite mid-run: count 6, rewrite to 1 after two ticks
    lock_in = 3'b000;
    wr(3'd2, 32'd6, "R9 count");
    wr(3'd0, 32'h0000_0002, "R9 enable");
    step("R9 run"); step("R9 run");
    wr(3'd2, 32'd1, "R9 rewrite");
    addr = 3'd4;
    step("R9 after rewrite");
    chk(rdata[1] === 1'b0, "R9 no restart", rdata, 32'd0);
    repeat (6) step("R9 run on");
    chk(rdata[1] === 1'b1, "R9 original expiry", rdata, 32'd2);
    // random phase with collisions
    for (int i = 0; i < 4000; i++) begin
      tick    = 1'($urandom);
      lock_in = 3'($urandom);
      if ($urandom_range(3, 0) == 0) begin
        wr_en = 1'b1;
        addr  = ($urandom_range(1, 0) == 0) ? 3'd0 : 3'($urandom_range(4, 1));
        wdata = (addr == 3'd0) ? $urandom : 32'($urandom_range(12, 0));
      end else begin
        addr = 3'($urandom_range(7, 0));
      end
      step("R6 R7 R8 R9 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule